// File: doc/BRIEF.md
# Control-Word Host Command Sequencer

This block sits on the host side of a two-wire serial bus and turns a single register request into block-format command frames for a target that holds clock-driver control words. A request names an operation (fetch a 32-bit group, store one byte, store a 32-bit group), an 8-bit register offset and the data to store. The block then steps a byte-level bus master through the frames one handshake at a time. The master carries out the start/stop conditions, single byte writes and single byte reads.

A store is one bus transaction. A fetch takes two. The first carries the full command frame. The second re-sends only the command byte, turns the bus around with a repeated start in read direction, and collects a six-byte response whose status byte decides success. Requests that the target would silently mis-address are refused before any bus activity. A refusal, a bus NACK and a bad status each return a distinct error code. Every request ends with a one-cycle `done` pulse that carries the results.

Top module: `cw_cmd_seq`

## Requirements
- R1: The command byte is 0xC2 combined (OR) with an operation code: 0x00 for a 32-bit fetch, 0x04 for a byte store, 0x0C for a 32-bit store. `req_op` encodes 0 = 32-bit fetch, 1 = byte store, 2 = 32-bit store. The value 3 is refused with error code 1.
- R2: The bus-op kinds on `m_kind` are 0 = START, 1 = WRITE, 2 = READ and 3 = STOP. A frame is a START carrying the address byte {DEV_ADDR, 0}, then the WRITE bytes command, count, 0x00, 0x00, 0x00, register offset, then the data, then a STOP. The count is 4 for a fetch, 5 for a byte store and 8 for a 32-bit store, and the frame carries count + 2 WRITE bytes.
- R3: A 32-bit store sends its data most-significant byte first, so bits [7:0] are the last byte on the bus.
- R4: After the first frame of a fetch, the block issues a START with {DEV_ADDR, 0}, the command byte alone, a START with {DEV_ADDR, 1} and `m_rd_dir` high, six READs with `m_last` high only on the sixth, and a STOP.
- R5: In the fetch response, byte 1 is the count (ignored), byte 2 is the status and bytes 3 to 6 are data. The first data byte lands in `rsp_rdata[31:24]`. A status of 0x01 gives `rsp_ok` = 1 and `rsp_err` = 0.
- R6: Any other status value gives `rsp_ok` = 0 and `rsp_err` = 3, and the data is still returned.
- R7: A store to an offset below FIRST_CW (0x08) or above LAST_CW (0x1E) is refused with `rsp_err` = 1. A refusal causes no bus activity, and `done` rises in the cycle after acceptance.
- R8: A 32-bit store whose offset has either of its two low bits set is refused with `rsp_err` = 1 and no bus activity.
- R9: A NACK on a START or WRITE aborts the request. The next bus op is a STOP, no further bytes are sent, and the result is `rsp_ok` = 0 with `rsp_err` = 2.
- R10: `busy` is high from the cycle after a bus request is accepted until its `done` cycle. A request presented while busy is ignored. `done` is a one-cycle pulse, and a request presented in the `done` cycle is accepted.
- R11: `m_req` stays high with stable `m_kind` and `m_wbyte` until the cycle in which `m_ack` or `m_nack` is seen.
- R12: After reset, `busy`, `done`, `m_req`, `rsp_ok`, `rsp_err` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | Operation: 0 fetch32, 1 store8, 2 store32 |
| req_addr | input | 8 | Register offset |
| req_wdata | input | 32 | Store data (byte store uses [7:0]) |
| busy | output | 1 | Bus request in progress |
| done | output | 1 | One-cycle result pulse |
| rsp_ok | output | 1 | Request succeeded |
| rsp_err | output | 2 | 0 none, 1 refused, 2 bus NACK, 3 bad status |
| rsp_rdata | output | 32 | Fetched word |
| m_req | output | 1 | Bus op request to the byte master |
| m_kind | output | 2 | Bus op kind: 0 START, 1 WRITE, 2 READ, 3 STOP |
| m_wbyte | output | 8 | Byte to send (address byte for START) |
| m_rd_dir | output | 1 | START is in read direction |
| m_last | output | 1 | This READ is the final byte |
| m_ack | input | 1 | Byte master completed the op |
| m_nack | input | 1 | Byte master saw a NACK |
| m_rbyte | input | 8 | Byte returned by a READ |

## Verification
The `done` of one request and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `req_valid` for a second request at the very sample point where it first sees `done` for the first. It then judges that the second request's whole bus-op stream follows with no lost or duplicated ops, and that `done` comes exactly once for each request. A related overlap, a request arriving mid-transfer, is provoked by pulsing `req_valid` while `busy` is high. The bench then confirms that the op stream and the result count are unchanged.

// File: rtl/cw_seq_pkg.sv
// Shared encodings for the control-word command sequencer.
// Assumes an 8-bit register offset space and 32-bit fetch groups.
package cw_seq_pkg;

    typedef enum logic [1:0] {
        OP_FETCH32 = 2'd0,
        OP_STORE8  = 2'd1,
        OP_STORE32 = 2'd2,
        OP_BAD     = 2'd3
    } cw_op_e;

    typedef enum logic [1:0] {
        BUS_START = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2,
        BUS_STOP  = 2'd3
    } bus_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_REFUSED = 2'd1,
        ERR_NACK    = 2'd2,
        ERR_STATUS  = 2'd3
    } cw_err_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_SEND, ST_STOP, ST_START2,
        ST_CMD2, ST_RSTART, ST_RECV, ST_FIN_STOP, ST_ABORT
    } seq_state_e;

    localparam logic [7:0] CMD_BLOCK   = 8'hC2;
    localparam logic [7:0] STATUS_GOOD = 8'h01;
    localparam int         RSP_BYTES   = 6;

    // Command byte for an operation: block framing bits plus op code.
    function automatic logic [7:0] cmd_byte(input cw_op_e op);
        case (op)
            OP_STORE8:  return CMD_BLOCK | 8'h04;
            OP_STORE32: return CMD_BLOCK | 8'h0C;
            default:    return CMD_BLOCK;
        endcase
    endfunction

endpackage

// File: rtl/cw_frame_mux.sv
// Frame byte selector: yields the byte at position idx of the command
// frame for the latched request, and the index of the frame's last byte.
// Assumes the request fields are held stable for the whole transfer.
module cw_frame_mux
    import cw_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cw_op_e              op,
    input  logic [7:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [3:0]          idx,
    output logic [7:0]          byte_o,
    output logic [3:0]          last_idx
);
    localparam int NB = DATA_W / 8;

    logic [7:0] count;

    // Count field: header bytes after the count, plus the payload.
    always_comb begin
        case (op)
            OP_STORE8:  count = 8'd5;
            OP_STORE32: count = 8'(4 + NB);
            default:    count = 8'd4;
        endcase
        last_idx = 4'(count + 8'd1);
    end

    // Byte select; the store payload is sent most-significant byte first.
    always_comb begin
        byte_o = 8'h00;
        if (idx == 4'd0)
            byte_o = cmd_byte(op);
        else if (idx == 4'd1)
            byte_o = count;
        else if (idx == 4'd5)
            byte_o = addr;
        else if (idx >= 4'd6) begin
            if (op == OP_STORE8)
                byte_o = wdata[7:0];
            else
                byte_o = wdata[8*(NB-1-(int'(idx)-6)) +: 8];
        end
    end
endmodule

// File: rtl/cw_rsp_collect.sv
// Response collector: captures the status byte and shifts data bytes in
// so the first data byte ends in the top byte of the word.
// Assumes capture indices 0..5 arrive in order within one fetch.
module cw_rsp_collect
    import cw_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap,
    input  logic [3:0]        idx,
    input  logic [7:0]        rbyte,
    output logic [7:0]        status,
    output logic [DATA_W-1:0] data
);
    // Capture status and data bytes of the response.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            status <= 8'h00;
            data   <= '0;
        end else if (cap) begin
            if (idx == 4'd1)
                status <= rbyte;
            else if (idx >= 4'd2)
                data <= {data[DATA_W-9:0], rbyte};
        end
    end

    AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> idx < 4'(RSP_BYTES)); // R4
endmodule

// File: rtl/cw_cmd_seq.sv
// Control-word command sequencer top. Accepts one request at a time,
// refuses mis-addressed stores, drives a byte-level bus master through
// the frames and reports a result with a one-cycle done pulse.
// Assumes the master answers each m_req with exactly one m_ack or m_nack.
module cw_cmd_seq
    import cw_seq_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h58,
    parameter logic [7:0] FIRST_CW = 8'h08,
    parameter logic [7:0] LAST_CW  = 8'h1E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic        rsp_ok,
    output logic [1:0]  rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        m_req,
    output logic [1:0]  m_kind,
    output logic [7:0]  m_wbyte,
    output logic        m_rd_dir,
    output logic        m_last,
    input  logic        m_ack,
    input  logic        m_nack,
    input  logic [7:0]  m_rbyte
);
    localparam int DATA_W = 32;

    seq_state_e        state_q;
    cw_op_e            op_q;
    logic [7:0]        addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [3:0]        idx_q;
    logic [7:0]        frame_byte;
    logic [3:0]        last_idx;
    logic [7:0]        rsp_status;
    logic [DATA_W-1:0] rsp_data;
    bus_kind_e         kind;
    logic              refuse, is_store, step, abort;
    cw_op_e            req_op_e;

    assign req_op_e = cw_op_e'(req_op);

    // Decide whether a new request must be refused before touching the bus.
    always_comb begin
        is_store = (req_op_e == OP_STORE8) || (req_op_e == OP_STORE32);
        refuse   = (req_op_e == OP_BAD)
                || (is_store && (req_addr < FIRST_CW || req_addr > LAST_CW))
                || (req_op_e == OP_STORE32 && req_addr[1:0] != 2'b00);
    end

    cw_frame_mux #(.DATA_W(DATA_W)) u_frame (
        .op(op_q), .addr(addr_q), .wdata(wdata_q), .idx(idx_q),
        .byte_o(frame_byte), .last_idx(last_idx)
    );

    cw_rsp_collect #(.DATA_W(DATA_W)) u_rsp (
        .clk(clk), .rst_n(rst_n), .clear(state_q == ST_IDLE),
        .cap(state_q == ST_RECV && m_ack), .idx(idx_q), .rbyte(m_rbyte),
        .status(rsp_status), .data(rsp_data)
    );

    // Map the sequencer state to the bus op it requests.
    always_comb begin
        case (state_q)
            ST_START, ST_START2, ST_RSTART: kind = BUS_START;
            ST_SEND, ST_CMD2:               kind = BUS_WRITE;
            ST_RECV:                        kind = BUS_READ;
            default:                        kind = BUS_STOP;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign m_req    = busy;
    assign m_kind   = kind;
    assign m_rd_dir = (state_q == ST_RSTART);
    assign m_last   = (state_q == ST_RECV) && (idx_q == 4'(RSP_BYTES - 1));
    assign m_wbyte  = (kind == BUS_START) ? {DEV_ADDR, m_rd_dir} : frame_byte;
    assign abort    = m_nack && (kind != BUS_STOP);
    assign step     = m_ack || (m_nack && kind == BUS_STOP);

    // Main sequencer: request intake, frame stepping and result delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_FETCH32;
            addr_q    <= 8'h00;
            wdata_q   <= '0;
            idx_q     <= 4'd0;
            done      <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_err   <= ERR_NONE;
            rsp_rdata <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (req_valid && refuse) begin
                    done      <= 1'b1;
                    rsp_ok    <= 1'b0;
                    rsp_err   <= ERR_REFUSED;
                    rsp_rdata <= '0;
                end else if (req_valid) begin
                    op_q    <= req_op_e;
                    addr_q  <= req_addr;
                    wdata_q <= req_wdata;
                    idx_q   <= 4'd0;
                    state_q <= ST_START;
                end
            end else if (abort) begin
                state_q <= ST_ABORT;
            end else if (step) begin
                case (state_q)
                    ST_START:  begin idx_q <= 4'd0; state_q <= ST_SEND; end
                    ST_SEND:   if (idx_q == last_idx) state_q <= ST_STOP;
                               else idx_q <= idx_q + 4'd1;
                    ST_STOP:   if (op_q == OP_FETCH32) state_q <= ST_START2;
                               else begin
                                   state_q   <= ST_IDLE;
                                   done      <= 1'b1;
                                   rsp_ok    <= 1'b1;
                                   rsp_err   <= ERR_NONE;
                                   rsp_rdata <= '0;
                               end
                    ST_START2: begin idx_q <= 4'd0; state_q <= ST_CMD2; end
                    ST_CMD2:   state_q <= ST_RSTART;
                    ST_RSTART: begin idx_q <= 4'd0; state_q <= ST_RECV; end
                    ST_RECV:   if (idx_q == 4'(RSP_BYTES - 1)) state_q <= ST_FIN_STOP;
                               else idx_q <= idx_q + 4'd1;
                    ST_FIN_STOP: begin
                        state_q   <= ST_IDLE;
                        done      <= 1'b1;
                        rsp_ok    <= (rsp_status == STATUS_GOOD);
                        rsp_err   <= (rsp_status == STATUS_GOOD) ? ERR_NONE : ERR_STATUS;
                        rsp_rdata <= rsp_data;
                    end
                    ST_ABORT: begin
                        state_q   <= ST_IDLE;
                        done      <= 1'b1;
                        rsp_ok    <= 1'b0;
                        rsp_err   <= ERR_NACK;
                        rsp_rdata <= '0;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack && !m_nack) |=> (m_req && $stable(m_kind) && $stable(m_wbyte))); // R11
    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && refuse) |=> (!m_req && done && rsp_err == ERR_REFUSED)); // R7
    AST_NACK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_nack && m_kind != BUS_STOP) |=> (m_req && m_kind == BUS_STOP)); // R9
    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_kind == BUS_WRITE && idx_q == 4'd0) |-> (m_wbyte[7:6] == 2'b11 && m_wbyte[1]));  // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_ok) |-> rsp_err == ERR_NONE); // R5
endmodule

// File: tb/cw_cmd_seq_tb.sv
module cw_cmd_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic        busy, done, rsp_ok, m_req, m_rd_dir, m_last;
    logic [1:0]  rsp_err, m_kind;
    logic [31:0] rsp_rdata;
    logic [7:0]  m_wbyte;
    logic        m_ack = 1'b0, m_nack = 1'b0;
    logic [7:0]  m_rbyte = 8'h00;

    int checks = 0;
    int failures = 0;
    bit active = 1'b0;
    int nack_at = -1;
    int op_seen = 0;
    int exp_kind[$];
    int exp_byte[$];
    int rsp_q[$];

    always #5 clk = ~clk;

    cw_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rsp_ok(rsp_ok), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .m_req(m_req), .m_kind(m_kind), .m_wbyte(m_wbyte), .m_rd_dir(m_rd_dir),
        .m_last(m_last), .m_ack(m_ack), .m_nack(m_nack), .m_rbyte(m_rbyte)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void push(input int k, input int b);
        exp_kind.push_back(k);
        exp_byte.push_back(b);
    endfunction

    // Reference op stream built from the requirements (R2, R3, R4, R1).
    function automatic void build(input int op, input int addr, input int wd, input int nk);
        int cmd, cnt;
        cmd = (op == 1) ? 'hC6 : (op == 2) ? 'hCE : 'hC2;
        cnt = (op == 1) ? 5 : (op == 2) ? 8 : 4;
        push(0, 'hB0); push(1, cmd); push(1, cnt); push(1, 0); push(1, 0); push(1, 0); push(1, addr);
        if (op == 1) push(1, wd & 'hFF);
        if (op == 2) for (int s = 3; s >= 0; s--) push(1, (wd >> (8*s)) & 'hFF);
        push(3, 0);
        if (op == 0) begin
            push(0, 'hB0); push(1, cmd); push(0, 'hB1);
            for (int r = 0; r < 6; r++) push(2, (r == 5) ? 1 : 0);
            push(3, 0);
        end
        if (nk >= 0) begin
            while (exp_kind.size() > nk + 1) begin void'(exp_kind.pop_back()); void'(exp_byte.pop_back()); end
            push(3, 0);
        end
    endfunction

    // Byte-master model: checks each op against the reference stream and answers it.
    initial begin
        @(negedge clk);
        forever begin
            if (m_req) begin
                int k, b;
                if (exp_kind.size() == 0) begin
                    check(0, "R9/R10 unexpected bus op", m_kind, 99);
                    k = int'(m_kind); b = 0;
                end else begin
                    k = exp_kind.pop_front(); b = exp_byte.pop_front();
                    check(int'(m_kind) == k, "R2 op kind", m_kind, k);
                    if (k == 0 || k == 1) check(int'(m_wbyte) == b, "R2 op byte", m_wbyte, b);
                    if (k == 0) check(m_rd_dir == b[0], "R4 read direction", m_rd_dir, b[0]);
                    if (k == 2) check(m_last == b[0], "R4 last read flag", m_last, b[0]);
                end
                repeat (2) @(negedge clk);
                check(m_req && int'(m_kind) == k, "R11 request held", m_kind, k);
                if (op_seen == nack_at) m_nack = 1'b1; else m_ack = 1'b1;
                if (k == 2 && rsp_q.size() > 0) m_rbyte = 8'(rsp_q.pop_front());
                op_seen++;
                @(negedge clk);
                m_ack = 1'b0; m_nack = 1'b0;
            end else
                @(negedge clk);
        end
    end

    // Per-clock protocol reference: no bus op or result outside a request.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n) begin
                check(!(m_req && !active), "R10 bus op without request", m_req, 0);
                check(!(done && !active), "R10 stray done", done, 0);
            end
        end
    end

    task automatic issue(input int op, input int addr, input int wd, input int nk, input bit bus);
        nack_at = nk; op_seen = 0; active = 1'b1;
        if (bus) build(op, addr, wd, nk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = 8'(addr); req_wdata = 32'(wd);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req, input bit ok, input int err, input int rd);
        while (!done) @(negedge clk);
        check(rsp_ok == ok, {req, " ok"}, rsp_ok, ok);
        check(int'(rsp_err) == err, {req, " err"}, rsp_err, err);
        check(rsp_rdata == 32'(rd), {req, " rdata"}, rsp_rdata, rd);
        check(!busy, "R10 idle at done", busy, 0);
        check(exp_kind.size() == 0, {req, " op stream complete"}, exp_kind.size(), 0);
        active = 1'b0;
    endtask

    task automatic load_rsp(input int st, input int w);
        rsp_q = {};
        rsp_q.push_back(5); rsp_q.push_back(st);
        for (int s = 3; s >= 0; s--) rsp_q.push_back((w >> (8*s)) & 'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !done && !m_req, "R12 reset outputs", {busy, done, m_req}, 0);
        check(!rsp_ok && rsp_err == 0 && rsp_rdata == 0, "R12 reset results", rsp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 byte store at the lowest legal offset
        issue(1, 'h08, 'hA5, -1, 1);
        check(busy, "R10 busy after accept", busy, 1);
        wait_done("R2 store8", 1, 0, 0);

        // R3 32-bit store, MSB first
        issue(2, 'h0C, 'h11223344, -1, 1);
        wait_done("R3 store32", 1, 0, 0);

        // R7 byte store at upper limit is accepted
        issue(1, 'h1E, 'h3C, -1, 1);
        wait_done("R7 store8 at upper limit", 1, 0, 0);

        // R8 misaligned 32-bit store refused, done next cycle, no bus op
        issue(2, 'h0D, 'h1, -1, 0);
        check(done && !m_req, "R8 refusal timing", done, 1);
        wait_done("R8 misaligned", 0, 1, 0);
        // R7 out-of-range offsets
        issue(1, 'h07, 'h1, -1, 0);
        wait_done("R7 below range", 0, 1, 0);
        issue(1, 'h1F, 'h1, -1, 0);
        wait_done("R7 above range", 0, 1, 0);
        // R1 op code 3 refused
        issue(3, 'h10, 'h1, -1, 0);
        wait_done("R1 bad op", 0, 1, 0);

        // R4 R5 fetch with good status
        load_rsp('h01, 'hDEADBEEF);
        issue(0, 'h00, 0, -1, 1);
        wait_done("R5 fetch", 1, 0, 'hDEADBEEF);

        // R6 fetch with bad status
        load_rsp('h10, 'h01020304);
        issue(0, 'h04, 0, -1, 1);
        wait_done("R6 bad status", 0, 3, 'h01020304);

        // R9 NACK on third frame byte of a store
        issue(2, 'h10, 'hCAFEF00D, 3, 1);
        wait_done("R9 nack on write", 0, 2, 0);
        // R9 NACK on the phase-two address byte of a fetch
        load_rsp('h01, 0);
        issue(0, 'h08, 0, 8, 1);
        wait_done("R9 nack on start", 0, 2, 0);

        // R10 request while busy is ignored
        issue(1, 'h09, 'h77, -1, 1);
        repeat (4) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done("R10 ignore while busy", 1, 0, 0);
        repeat (6) @(negedge clk);
        check(!m_req && !done, "R10 nothing after ignored request", m_req, 0);

        // R10 new request in the done cycle
        issue(1, 'h0A, 'h12, -1, 1);
        wait_done("R10 first of pair", 1, 0, 0);
        load_rsp('h01, 'hA0B0C0D0);
        issue(0, 'h1C, 0, -1, 1);
        wait_done("R10 second of pair", 1, 0, 'hA0B0C0D0);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule